// File: doc/BRIEF.md
# Prioritized Nesting Interrupt Controller

This block arbitrates among a fixed set of interrupt sources and tells the instruction sequencer when to branch to a handler. Sources are ranked by index: index 0 is the most urgent. The lowest-numbered sources are external request pins, which are active low and pass through a two-stage synchronizer. Each pin can be set up as edge-triggered or level-triggered. The remaining sources are internal pulse requests, and these always behave as edge-triggered.

A positive-sense enable mask and a global enable select which pending requests may win. On acceptance the block issues a one-cycle take strobe with the handler vector, the mask value that the sequencer must push on its status stack, and a new mask for the handler. The new mask depends on the nesting setting. The cycle after a take is flagged as an inserted no-operation while the vector is fetched. On return from a handler the sequencer hands back the saved mask, and the block restores it.

Software can force or clear any edge-type request. Both actions take effect one cycle after the write. The configuration register also takes effect one cycle after it is written.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the mask is all zeros, `take_o`, `nop_o`, `vec_o` and `save_mask_o` are zero, the configuration is all zeros (every pin level-triggered, nesting off) and the global enable is on.
- R2: Among the requests that are both pending and enabled by their mask bit, the lowest index wins. The vector for source k is 4*(k+1), so source 0 gets 0x0004 and each further source adds 4 words.
- R3: For a pin in edge mode, a high-to-low transition sets a sticky pending bit. If the request is enabled, `take_o` is high in the fourth cycle after the first clock edge that sees the low pin. Servicing clears the bit, so a pin that stays low is not serviced again.
- R4: For a pin in level mode nothing is latched. An enabled low pin gives the same four-cycle latency and is serviced again after return while it stays low. A low pulse that ends while the source is masked is lost.
- R5: An edge request that arrives while its mask bit is 0 is held. When a mask write enables it, `take_o` rises two cycles after the clock edge that performs the write.
- R6: A force bit makes an edge-type source pending one cycle after the write, and that source is serviced once. A force bit aimed at a pin in level mode has no effect.
- R7: A clear bit drops an edge-type pending request one cycle after the write. If a clear and a set or force reach the same bit in the same cycle, the clear wins.
- R8: On acceptance of source k, `save_mask_o` carries the mask as it was before the take. With nesting off the mask becomes all zeros. With nesting on, mask bits k and above are cleared and bits below k are kept.
- R9: In the configuration word, bit 4 is the nesting enable and bit j (for j < number of pins) sets pin j to edge mode when 1 and level mode when 0. A written value is used from the second clock edge after the write.
- R10: While the global enable is off, no request is taken. `gie_clr_i` turns it off and `gie_set_i` turns it on. After a set, a waiting enabled request is taken on the next clock edge.
- R11: `nop_o` is high in the cycle after every `take_o`. No new take happens in the cycle after `take_o` or after `nop_o`.
- R12: `rti_i` loads the mask from `rti_mask_i`. A mask write or return in the same cycle as a possible acceptance defers that acceptance.
- R13: An internal request pulse sets a pending bit at the clock edge that samples it. If the request is enabled, `take_o` follows one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq_n_i | input | NUM_EXT | Active-low external request pins |
| int_req_i | input | NUM_SRC-NUM_EXT | Internal request pulses, active high |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | NUM_SRC | Mask write data, bit k enables source k |
| ctl_we_i | input | 1 | Configuration write strobe |
| ctl_wdata_i | input | 5 | Configuration data: bit 4 nesting, low bits pin modes |
| force_i | input | NUM_SRC | Force strobes, one per source |
| clear_i | input | NUM_SRC | Clear strobes, one per source |
| gie_set_i | input | 1 | Turn global enable on |
| gie_clr_i | input | 1 | Turn global enable off |
| rti_i | input | 1 | Return from handler |
| rti_mask_i | input | NUM_SRC | Mask popped from the status stack |
| take_o | output | 1 | Acceptance strobe, also the status push request |
| vec_o | output | 14 | Handler vector of the last acceptance |
| save_mask_o | output | NUM_SRC | Mask value to push |
| nop_o | output | 1 | Inserted no-operation cycle |
| mask_o | output | NUM_SRC | Current mask |

## Verification
Two collisions are provoked on purpose, and each is judged at the ports. In the first, an acceptance would fall in the same cycle as a mask write or a return. The bench turns on the global enable with a request already waiting, then issues a mask write on the very next cycle. It expects `take_o` to stay low until the mask-write guard cycle has passed. In the second, a clear and a force hit the same source in one cycle. The bench then enables that source and expects no take. Random force patterns combined with random masks and nesting settings check the winner, the vector, the saved mask and the handler mask against bench functions.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int VEC_W   = 14;
    localparam int CTL_W   = 5;
    localparam int MAX_EXT = 4;

    typedef enum logic {
        SENS_LEVEL = 1'b0,
        SENS_EDGE  = 1'b1
    } sens_e;

    // configuration word: nesting enable on the top bit, pin modes below
    typedef struct packed {
        logic               nest_en;
        logic [MAX_EXT-1:0] sens;
    } ctl_t;

    function automatic logic [VEC_W-1:0] vec_addr(input int unsigned idx);
        return VEC_W'((idx + 1) << 2);
    endfunction

endpackage

// File: rtl/irqc_ext_front.sv
module irqc_ext_front #(
    parameter int NUM_EXT = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EXT-1:0] pin_n_i,
    output logic [NUM_EXT-1:0] fall_o,
    output logic [NUM_EXT-1:0] low_o
);

    for (genvar g = 0; g < NUM_EXT; g++) begin : g_pin
        logic s1_q, s2_q, s3_q, low_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                s1_q  <= 1'b1;
                s2_q  <= 1'b1;
                s3_q  <= 1'b1;
                low_q <= 1'b0;
            end else begin
                s1_q  <= pin_n_i[g];
                s2_q  <= s1_q;
                s3_q  <= s2_q;
                low_q <= ~s2_q;
            end
        end

        assign fall_o[g] = s3_q & ~s2_q;
        assign low_o[g]  = low_q;

        // R3: a detected falling edge is followed by a low level indication
        p_fall_then_low_r3: assert property (@(posedge clk) disable iff (rst)
            fall_o[g] |=> low_o[g]);
    end

endmodule

// File: rtl/irqc_pend.sv
module irqc_pend #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] force_i,
    input  logic [N-1:0] clear_i,
    input  logic [N-1:0] svc_i,
    input  logic [N-1:0] edge_i,
    output logic [N-1:0] pend_o
);

    logic [N-1:0] force_q, clr_q, pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            force_q <= '0;
            clr_q   <= '0;
            pend_q  <= '0;
        end else begin
            force_q <= force_i;
            clr_q   <= clear_i;
            pend_q  <= edge_i & (((pend_q & ~svc_i) | set_i | force_q) & ~clr_q);
        end
    end

    assign pend_o = pend_q;

    // R7: a delayed clear always empties its bits, whatever arrives with it
    p_clear_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (|clr_q) |=> ((pend_q & $past(clr_q)) == '0));

endmodule

// File: rtl/irqc_arb.sv
module irqc_arb #(
    parameter int N     = 6,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req_i,
    output logic [N-1:0]     grant_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);

    always_comb begin
        grant_o = '0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
                idx_o      = IDX_W'(i);
            end
        end
    end

    assign any_o = |req_i;

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 6,
    parameter int NUM_EXT = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_EXT-1:0]         ext_irq_n_i,
    input  logic [NUM_SRC-NUM_EXT-1:0] int_req_i,
    input  logic                       mask_we_i,
    input  logic [NUM_SRC-1:0]         mask_wdata_i,
    input  logic                       ctl_we_i,
    input  logic [CTL_W-1:0]           ctl_wdata_i,
    input  logic [NUM_SRC-1:0]         force_i,
    input  logic [NUM_SRC-1:0]         clear_i,
    input  logic                       gie_set_i,
    input  logic                       gie_clr_i,
    input  logic                       rti_i,
    input  logic [NUM_SRC-1:0]         rti_mask_i,
    output logic                       take_o,
    output logic [VEC_W-1:0]           vec_o,
    output logic [NUM_SRC-1:0]         save_mask_o,
    output logic                       nop_o,
    output logic [NUM_SRC-1:0]         mask_o
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    ctl_t               ctl_q, ctl_eff;
    logic [NUM_SRC-1:0] mask_q, save_q, grant_q;
    logic               gie_q, hold_q, take_q, nop_q;
    logic [VEC_W-1:0]   vec_q;

    logic [NUM_EXT-1:0] fall, low;
    logic [NUM_SRC-1:0] edge_type, set_vec, lvl_req, pend, req, cand;
    logic [NUM_SRC-1:0] grant, svc, entry;
    logic [IDX_W-1:0]   idx;
    logic               any, take_ok;
    logic               ctl_unused;

    assign ctl_unused = ^ctl_eff.sens;

    irqc_ext_front #(.NUM_EXT(NUM_EXT)) u_front (
        .clk     (clk),
        .rst     (rst),
        .pin_n_i (ext_irq_n_i),
        .fall_o  (fall),
        .low_o   (low)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        if (g < NUM_EXT) begin : g_ext
            assign edge_type[g] = (ctl_eff.sens[g] == SENS_EDGE);
            assign set_vec[g]   = fall[g];
            assign lvl_req[g]   = low[g];
        end else begin : g_int
            assign edge_type[g] = 1'b1;
            assign set_vec[g]   = int_req_i[g-NUM_EXT];
            assign lvl_req[g]   = 1'b0;
        end
    end

    irqc_pend #(.N(NUM_SRC)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .set_i   (set_vec),
        .force_i (force_i),
        .clear_i (clear_i),
        .svc_i   (svc),
        .edge_i  (edge_type),
        .pend_o  (pend)
    );

    assign req  = (edge_type & pend) | (~edge_type & lvl_req);
    assign cand = req & mask_q;

    irqc_arb #(.N(NUM_SRC), .IDX_W(IDX_W)) u_arb (
        .req_i   (cand),
        .grant_o (grant),
        .idx_o   (idx),
        .any_o   (any)
    );

    assign take_ok = any & gie_q & ~hold_q & ~take_q & ~nop_q & ~mask_we_i & ~rti_i;
    assign svc     = take_ok ? grant : '0;

    // handler mask: keep only strictly more urgent bits when nesting
    always_comb begin
        entry = '0;
        for (int j = 0; j < NUM_SRC; j++) begin
            if (ctl_eff.nest_en && (j < int'(idx))) begin
                entry[j] = mask_q[j];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            ctl_eff <= '0;
            mask_q  <= '0;
            gie_q   <= 1'b1;
            hold_q  <= 1'b0;
            take_q  <= 1'b0;
            nop_q   <= 1'b0;
            vec_q   <= '0;
            save_q  <= '0;
            grant_q <= '0;
        end else begin
            ctl_eff <= ctl_q;
            if (ctl_we_i) begin
                ctl_q <= ctl_t'(ctl_wdata_i);
            end
            hold_q <= mask_we_i;
            take_q <= take_ok;
            nop_q  <= take_q;
            if (gie_clr_i) begin
                gie_q <= 1'b0;
            end else if (gie_set_i) begin
                gie_q <= 1'b1;
            end
            if (take_ok) begin
                mask_q  <= entry;
                save_q  <= mask_q;
                grant_q <= grant;
                vec_q   <= vec_addr(32'(idx));
            end else if (rti_i) begin
                mask_q <= rti_mask_i;
            end else if (mask_we_i) begin
                mask_q <= mask_wdata_i;
            end
        end
    end

    assign take_o      = take_q;
    assign nop_o       = nop_q;
    assign vec_o       = vec_q;
    assign save_mask_o = save_q;
    assign mask_o      = mask_q;

    // R2: the serviced source was enabled in the mask that was saved
    p_grant_enabled_r2: assert property (@(posedge clk) disable iff (rst)
        take_q |-> |(grant_q & save_q));

    // R8: the handler mask never enables anything the saved mask did not
    p_entry_subset_r8: assert property (@(posedge clk) disable iff (rst)
        take_q |-> ((mask_q & ~save_q) == '0));

    // R11: inserted no-operation follows every take
    p_nop_follows_r11: assert property (@(posedge clk) disable iff (rst)
        take_q |=> nop_q);

    // R11: no back-to-back takes while the vector fetch is in flight
    p_no_take_busy_r11: assert property (@(posedge clk) disable iff (rst)
        (take_q || nop_q) |=> !take_q);

    // R12: a mask write or return defers acceptance
    p_mask_write_defers_r12: assert property (@(posedge clk) disable iff (rst)
        (mask_we_i || rti_i) |=> !take_q);

    // R10: nothing is taken while globally disabled
    p_gie_blocks_r10: assert property (@(posedge clk) disable iff (rst)
        !gie_q |=> !take_q);

endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;

    localparam int NS = 6;
    localparam int NE = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NE-1:0] ext_n = '1;
    logic [NS-NE-1:0] ireq = '0;
    logic          mask_we = 1'b0;
    logic [NS-1:0] mask_wd = '0;
    logic          ctl_we = 1'b0;
    logic [4:0]    ctl_wd = '0;
    logic [NS-1:0] frc = '0;
    logic [NS-1:0] clr = '0;
    logic          gset = 1'b0;
    logic          gclr = 1'b0;
    logic          rti = 1'b0;
    logic [NS-1:0] rti_m = '0;
    logic          take, nop;
    logic [13:0]   vec;
    logic [NS-1:0] save_m, mask;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int cyc = 0;

    always #10 clk = ~clk;

    irq_prio_ctrl #(.NUM_SRC(NS), .NUM_EXT(NE)) u_dut (
        .clk(clk), .rst(rst), .ext_irq_n_i(ext_n), .int_req_i(ireq),
        .mask_we_i(mask_we), .mask_wdata_i(mask_wd), .ctl_we_i(ctl_we),
        .ctl_wdata_i(ctl_wd), .force_i(frc), .clear_i(clr),
        .gie_set_i(gset), .gie_clr_i(gclr), .rti_i(rti), .rti_mask_i(rti_m),
        .take_o(take), .vec_o(vec), .save_mask_o(save_m), .nop_o(nop),
        .mask_o(mask)
    );

    function automatic int exp_vec(input int k);
        return (k + 1) * 4;
    endfunction

    function automatic int lowest(input logic [NS-1:0] x);
        for (int i = NS - 1; i >= 0; i--) if (x[i]) lowest = i;
        if (x == '0) lowest = -1;
    endfunction

    function automatic logic [NS-1:0] exp_entry(input logic [NS-1:0] m, input int k,
                                                input bit nest);
        logic [NS-1:0] r = '0;
        if (nest) for (int j = 0; j < k; j++) r[j] = m[j];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr_ctl(input logic [4:0] v);
        ctl_we = 1'b1; ctl_wd = v; step(1); ctl_we = 1'b0; step(1);
    endtask

    task automatic wr_mask(input logic [NS-1:0] v);
        mask_we = 1'b1; mask_wd = v; step(1); mask_we = 1'b0; step(1);
    endtask

    task automatic do_rti(input logic [NS-1:0] v);
        rti = 1'b1; rti_m = v; step(1); rti = 1'b0;
    endtask

    task automatic force_bits(input logic [NS-1:0] v);
        frc = v; step(1); frc = '0; step(1);
    endtask

    task automatic clear_bits(input logic [NS-1:0] v);
        clr = v; step(1); clr = '0; step(1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 40000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4711);
        step(3);
        rst = 1'b0;
        step(1);

        // R1 reset state
        chk("R1 mask", 32'(mask), 0);
        chk("R1 take", 32'(take), 0);
        chk("R1 nop", 32'(nop), 0);
        chk("R1 vec", 32'(vec), 0);

        // R13 internal pulse, source 4
        wr_mask(6'b010000);
        ireq = 3'b010; step(1); ireq = '0;
        chk("R13 no take yet", 32'(take), 0);
        step(1);
        chk("R13 take", 32'(take), 1);
        chk("R2 vec src4", 32'(vec), exp_vec(4));
        chk("R8 save", 32'(save_m), 32'h10);
        chk("R8 mask zero nest off", 32'(mask), 0);
        step(1);
        chk("R11 nop", 32'(nop), 1);
        chk("R11 no take during nop", 32'(take), 0);
        do_rti(6'b0);

        // R3 edge pin 0
        wr_ctl(5'b00001);
        wr_mask(6'b000001);
        ext_n[0] = 1'b0;
        step(3);
        chk("R3 latency early", 32'(take), 0);
        step(1);
        chk("R3 take", 32'(take), 1);
        chk("R3 vec", 32'(vec), exp_vec(0));
        step(1);
        do_rti(6'b000001);
        chk("R12 rti mask", 32'(mask), 1);
        step(3);
        chk("R3 no repeat", 32'(take), 0);
        ext_n[0] = 1'b1;
        step(3);

        // R5 masked edge held
        wr_mask(6'b0);
        ext_n[0] = 1'b0; step(2); ext_n[0] = 1'b1; step(4);
        chk("R5 masked idle", 32'(take), 0);
        mask_we = 1'b1; mask_wd = 6'b000001; step(1); mask_we = 1'b0;
        chk("R5 after write", 32'(take), 0);
        step(1);
        chk("R5 guard cycle", 32'(take), 0);
        step(1);
        chk("R5 take", 32'(take), 1);
        chk("R5 vec", 32'(vec), exp_vec(0));
        step(1);
        do_rti(6'b0);

        // R4 level pin 1
        wr_mask(6'b000010);
        ext_n[1] = 1'b0;
        step(4);
        chk("R4 take", 32'(take), 1);
        chk("R4 vec", 32'(vec), exp_vec(1));
        step(1);
        do_rti(6'b000010);
        chk("R4 rti cycle", 32'(take), 0);
        step(1);
        chk("R4 retake while low", 32'(take), 1);
        ext_n[1] = 1'b1;
        step(3);
        do_rti(6'b000010);
        step(3);
        chk("R4 released", 32'(take), 0);
        wr_mask(6'b0);
        ext_n[1] = 1'b0; step(3); ext_n[1] = 1'b1; step(4);
        wr_mask(6'b000010);
        step(2);
        chk("R4 pulse not latched", 32'(take), 0);

        // R6 force
        wr_mask(6'b0);
        force_bits(6'b000100);
        wr_mask(6'b000100);
        step(2);
        chk("R6 force on level pin ignored", 32'(take), 0);
        wr_mask(6'b0);
        force_bits(6'b001000);
        mask_we = 1'b1; mask_wd = 6'b001000; step(1); mask_we = 1'b0;
        step(1);
        chk("R6 guard", 32'(take), 0);
        step(1);
        chk("R6 forced take", 32'(take), 1);
        chk("R6 vec", 32'(vec), exp_vec(3));
        step(1);
        do_rti(6'b001000);
        step(3);
        chk("R6 once only", 32'(take), 0);

        // R7 clear
        wr_mask(6'b0);
        force_bits(6'b001000);
        clear_bits(6'b001000);
        wr_mask(6'b001000);
        step(2);
        chk("R7 cleared", 32'(take), 0);
        wr_mask(6'b0);
        frc = 6'b001000; clr = 6'b001000; step(1); frc = '0; clr = '0; step(1);
        wr_mask(6'b001000);
        step(2);
        chk("R7 clear beats force", 32'(take), 0);

        // R9 configuration latency: force arrives while pin 2 still level
        wr_mask(6'b0);
        ctl_we = 1'b1; ctl_wd = 5'b00101; frc = 6'b000100;
        step(1); ctl_we = 1'b0; frc = '0; step(2);
        wr_mask(6'b000100);
        step(2);
        chk("R9 old mode still used", 32'(take), 0);
        force_bits(6'b000100);
        chk("R9 early", 32'(take), 0);
        step(1);
        chk("R9 edge mode take", 32'(take), 1);
        chk("R9 vec", 32'(vec), exp_vec(2));
        step(1);
        do_rti(6'b0);

        // R8 nesting and R10 global enable
        wr_ctl(5'b10101);
        gclr = 1'b1; step(1); gclr = 1'b0;
        wr_mask(6'b0);
        force_bits(6'b101000);
        wr_mask(6'b111110);
        step(4);
        chk("R10 disabled", 32'(take), 0);
        gset = 1'b1; step(1); gset = 1'b0;
        chk("R10 set edge", 32'(take), 0);
        step(1);
        chk("R10 take after enable", 32'(take), 1);
        chk("R8 nest vec", 32'(vec), exp_vec(3));
        chk("R8 nest save", 32'(save_m), 32'h3e);
        chk("R8 nest mask", 32'(mask), 32'(exp_entry(6'b111110, 3, 1'b1)));
        step(1);
        do_rti(6'b111110);
        chk("R12 rti defers", 32'(take), 0);
        step(1);
        chk("R8 second take", 32'(take), 1);
        chk("R8 second vec", 32'(vec), exp_vec(5));
        chk("R8 second mask", 32'(mask), 32'(exp_entry(6'b111110, 5, 1'b1)));
        step(1);
        do_rti(6'b0);

        // R12 acceptance collides with a mask write
        gclr = 1'b1; step(1); gclr = 1'b0;
        force_bits(6'b010000);
        wr_mask(6'b010000);
        gset = 1'b1; step(1); gset = 1'b0;
        chk("R12 gie edge", 32'(take), 0);
        mask_we = 1'b1; mask_wd = 6'b010000; step(1); mask_we = 1'b0;
        chk("R12 write wins", 32'(take), 0);
        step(1);
        chk("R12 guard", 32'(take), 0);
        step(1);
        chk("R12 deferred take", 32'(take), 1);
        chk("R12 vec", 32'(vec), exp_vec(4));
        step(1);
        do_rti(6'b0);

        // random priority patterns (R2, R6, R8)
        for (int it = 0; it < 40; it++) begin
            logic [NS-1:0] f, m, hit;
            bit nest;
            int k;
            f = NS'($urandom);
            m = NS'($urandom);
            nest = 1'($urandom);
            hit = f & m;
            k = lowest(hit);
            wr_ctl({nest, 4'b0111});
            wr_mask(6'b0);
            force_bits(f);
            mask_we = 1'b1; mask_wd = m; step(1); mask_we = 1'b0;
            step(1);
            chk("R5 random guard", 32'(take), 0);
            step(1);
            if (k >= 0) begin
                chk("R2 random take", 32'(take), 1);
                chk("R2 random vec", 32'(vec), exp_vec(k));
                chk("R8 random save", 32'(save_m), 32'(m));
                chk("R8 random mask", 32'(mask), 32'(exp_entry(m, k, nest)));
            end else begin
                chk("R2 random idle", 32'(take), 0);
            end
            step(1);
            do_rti(6'b0);
            clear_bits(6'h3f);
            step(1);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule